// File: doc/BRIEF.md
# Memory Attribute Range Configuration Bank

This block holds the configuration state that tells an address-lookup stage which caching attribute applies to each physical address range. It has a read-only capability word, a control word that carries the default attribute and two enable bits, eleven fixed-range words, and a parameterised number of variable-range pairs. Each pair is a base word and a mask word. Every register is 64 bits wide. The full contents leave the block on wide export buses, so the lookup stage can read them every cycle with no port contention.

Software reaches the bank through one register port. The port has one index input, a write strobe with write data, and a combinational read-data output for the selected index. The bank validates every write against the layout of the target register. A write that uses an unknown attribute code, sets a reserved bit, targets the capability word, or targets an index with no register behind it is refused. A refused write leaves every register as it was and raises a single-cycle fault pulse on the next cycle. The block that receives this pulse decides what the fault means.

Attribute codes: 0 uncached, 1 write-combining, 4 write-through, 5 write-protect, 6 write-back. No other value is accepted.

Register indices:
- 0: capability word.
- 1: control word.
- 2 to 12: the fixed-range words.
- 13+2k: base word of variable pair k.
- 14+2k: mask word of variable pair k.

Top module: `memtype_cfg_bank`

## Requirements
- R1: After reset, the control word, all fixed-range words and all variable base/mask words read as zero. The exported default attribute, fixed enable and global enable are all 0, and no fault is signalled.
- R2: The capability word (index 0) reads NUM_VAR in bits 7:0, 1 in bit 8 (fixed ranges present), WC_OK in bit 10 (write-combining supported) and SMM_OK in bit 11 (system-management pair supported). All other bits read zero, so the default parameters give 0x508.
- R3: Any write to the capability word faults and leaves its value unchanged.
- R4: An accepted write to the control word (index 1) stores the default attribute in bits 7:0, the fixed-range enable in bit 10 and the global enable in bit 11. These values appear on def_type_o, fixed_en_o and global_en_o from the cycle after the write.
- R5: A control-word write whose bits 7:0 are not 0, 1, 4, 5 or 6 faults and leaves the word unchanged.
- R6: A control-word write with any of bits 8, 9 or 12 to 63 set faults and leaves the word unchanged.
- R7: Attribute code 1 (write-combining) is accepted only when WC_OK is 1. When WC_OK is 0, any control, fixed or base write that carries code 1 in an attribute byte faults.
- R8: A fixed-range word (indices 2 to 12) holds eight attribute bytes. The write is accepted only if all eight bytes are legal codes, and the stored word appears in its 64-bit slice of fixed_ranges_o.
- R9: A variable base word holds the attribute in bits 7:0 and the base address in bits 12 to PA_W-1. A write with an illegal attribute, or with any of bits 8 to 11 or PA_W to 63 set, faults.
- R10: A variable mask word holds the valid flag in bit 11 and the mask in bits 12 to PA_W-1. A write with any of bits 0 to 10 or PA_W to 63 set faults. An accepted base or mask word appears in slice k of var_base_o or var_mask_o.
- R11: The fault output is high for exactly the one cycle after each refused write and low after accepted writes. A refused write that directly follows an accepted one faults on its own cycle and keeps the first write's value.
- R12: A write to an index of NREG or above (29 and up by default) faults, and a read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Contents of the indexed register (combinational) |
| fault | output | 1 | One-cycle pulse after a refused write |
| def_type_o | output | 8 | Default attribute code |
| fixed_en_o | output | 1 | Fixed-range enable bit |
| global_en_o | output | 1 | Global enable bit |
| fixed_ranges_o | output | 11*64 | All fixed-range words, word j at bits 64j+63:64j |
| var_base_o | output | NUM_VAR*64 | Base words, pair k at bits 64k+63:64k |
| var_mask_o | output | NUM_VAR*64 | Mask words, pair k at bits 64k+63:64k |

## Verification
Two activities can meet in the same cycle: the register update of an accepted write and the fault pulse of a refused write. This happens when two writes to one register go out on consecutive clock edges with the strobe held high. The bench sends an accepted word and then an illegal word back to back. It expects the fault output to stay low after the first edge and rise after the second. It also expects the register and its export slice to keep the first word. A second instance built without write-combining support shows that the legality of the same code depends on a parameter.

// File: rtl/memtype_pkg.sv
// Package: shared attribute codes, register index layout and legality function.
// Assumes indices are laid out: capability, control, 11 fixed, then base/mask pairs.
package memtype_pkg;

    typedef enum logic [7:0] {
        MT_UC = 8'd0,
        MT_WC = 8'd1,
        MT_WT = 8'd4,
        MT_WP = 8'd5,
        MT_WB = 8'd6
    } mem_type_e;

    localparam int CAP_IDX = 0;
    localparam int CTL_IDX = 1;
    localparam int FIX_IDX = 2;
    localparam int NUM_FIX = 11;
    localparam int VAR_IDX = FIX_IDX + NUM_FIX;

    // Legal attribute code, write-combining only when supported
    function automatic logic code_ok(input logic [7:0] code, input logic wc_ok);
        return (code == MT_UC) || (code == MT_WT) || (code == MT_WP) ||
               (code == MT_WB) || (wc_ok && code == MT_WC);
    endfunction

endpackage

// File: rtl/memtype_type_check.sv
// Module: checks one 8-bit attribute code against the legal set.
// Assumes the write-combining support is fixed at elaboration.
module memtype_type_check
    import memtype_pkg::*;
#(
    parameter bit WC_OK = 1'b1
) (
    input  logic [7:0] code,
    output logic       legal
);
    // Purpose: compare the code with the accepted encodings
    always_comb legal = code_ok(code, WC_OK);
endmodule

// File: rtl/memtype_wr_check.sv
// Module: decodes the write index and decides whether the write data is
// acceptable for the register it targets. Purely combinational.
// Assumes the index layout of memtype_pkg and PA_W < 64.
module memtype_wr_check
    import memtype_pkg::*;
#(
    parameter int NUM_VAR = 8,
    parameter int PA_W    = 36,
    parameter bit WC_OK   = 1'b1,
    parameter int ADDR_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       data,
    output logic              accept
);
    localparam int          NREG      = VAR_IDX + 2 * NUM_VAR;
    localparam logic [63:0] HI_RSVD   = ~((64'd1 << PA_W) - 64'd1);
    localparam logic [63:0] CTL_RSVD  = ~64'h0000_0000_0000_0CFF;
    localparam logic [63:0] BASE_RSVD = HI_RSVD | 64'h0000_0000_0000_0F00;
    localparam logic [63:0] MASK_RSVD = HI_RSVD | 64'h0000_0000_0000_07FF;

    logic [7:0] byte_ok;
    logic       is_ctl, is_fix, is_var, is_mask;
    logic [ADDR_W:0] var_off;

    // One checker per attribute byte of the write data
    for (genvar b = 0; b < 8; b++) begin : g_byte
        memtype_type_check #(.WC_OK(WC_OK)) u_chk (
            .code  (data[8*b +: 8]),
            .legal (byte_ok[b])
        );
    end

    // Purpose: classify the target index
    always_comb begin
        var_off = {1'b0, addr} - (ADDR_W+1)'(VAR_IDX);
        is_ctl  = (int'(addr) == CTL_IDX);
        is_fix  = (int'(addr) >= FIX_IDX) && (int'(addr) < VAR_IDX);
        is_var  = (int'(addr) >= VAR_IDX) && (int'(addr) < NREG);
        is_mask = var_off[0];
    end

    // Purpose: apply the rule set of the target register
    always_comb begin
        accept = 1'b0;
        if (is_ctl)
            accept = byte_ok[0] && ((data & CTL_RSVD) == '0);
        else if (is_fix)
            accept = &byte_ok;
        else if (is_var && !is_mask)
            accept = byte_ok[0] && ((data & BASE_RSVD) == '0);
        else if (is_var && is_mask)
            accept = ((data & MASK_RSVD) == '0);
    end
endmodule

// File: rtl/memtype_cfg_bank.sv
// Module: top of the attribute configuration bank. Holds the control word,
// fixed-range words and variable pairs, refuses illegal writes with a
// one-cycle fault pulse and exports every register to the lookup logic.
// Assumes a synchronous active-low reset and one access per cycle.
module memtype_cfg_bank
    import memtype_pkg::*;
#(
    parameter int NUM_VAR = 8,
    parameter int PA_W    = 36,
    parameter bit WC_OK   = 1'b1,
    parameter bit SMM_OK  = 1'b0,
    parameter int NREG    = VAR_IDX + 2 * NUM_VAR,
    parameter int ADDR_W  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic                    wr_en,
    input  logic [63:0]             wr_data,
    output logic [63:0]             rd_data,
    output logic                    fault,
    output logic [7:0]              def_type_o,
    output logic                    fixed_en_o,
    output logic                    global_en_o,
    output logic [NUM_FIX*64-1:0]   fixed_ranges_o,
    output logic [NUM_VAR*64-1:0]   var_base_o,
    output logic [NUM_VAR*64-1:0]   var_mask_o
);
    localparam logic [63:0] CAP_VAL = {52'd0, SMM_OK, WC_OK, 1'b0, 1'b1, 8'(NUM_VAR)};

    logic [63:0] ctl_q;
    logic [63:0] fix_q  [NUM_FIX];
    logic [63:0] base_q [NUM_VAR];
    logic [63:0] mask_q [NUM_VAR];
    logic        accept, do_wr;

    memtype_wr_check #(
        .NUM_VAR (NUM_VAR),
        .PA_W    (PA_W),
        .WC_OK   (WC_OK),
        .ADDR_W  (ADDR_W)
    ) u_check (
        .addr   (acc_addr),
        .data   (wr_data),
        .accept (accept)
    );

    assign do_wr = wr_en && accept;

    // Purpose: store accepted writes into the targeted register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int j = 0; j < NUM_FIX; j++) fix_q[j] <= '0;
            for (int k = 0; k < NUM_VAR; k++) begin
                base_q[k] <= '0;
                mask_q[k] <= '0;
            end
        end else if (do_wr) begin
            if (int'(acc_addr) == CTL_IDX) ctl_q <= wr_data;
            for (int j = 0; j < NUM_FIX; j++)
                if (int'(acc_addr) == FIX_IDX + j) fix_q[j] <= wr_data;
            for (int k = 0; k < NUM_VAR; k++) begin
                if (int'(acc_addr) == VAR_IDX + 2*k)     base_q[k] <= wr_data;
                if (int'(acc_addr) == VAR_IDX + 2*k + 1) mask_q[k] <= wr_data;
            end
        end
    end

    // Purpose: pulse the fault for one cycle after a refused write
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= wr_en && !accept;
    end

    // Purpose: return the indexed register, zero for unmapped indices
    always_comb begin
        rd_data = '0;
        if (int'(acc_addr) == CAP_IDX) rd_data = CAP_VAL;
        if (int'(acc_addr) == CTL_IDX) rd_data = ctl_q;
        for (int j = 0; j < NUM_FIX; j++)
            if (int'(acc_addr) == FIX_IDX + j) rd_data = fix_q[j];
        for (int k = 0; k < NUM_VAR; k++) begin
            if (int'(acc_addr) == VAR_IDX + 2*k)     rd_data = base_q[k];
            if (int'(acc_addr) == VAR_IDX + 2*k + 1) rd_data = mask_q[k];
        end
    end

    assign def_type_o  = ctl_q[7:0];
    assign fixed_en_o  = ctl_q[10];
    assign global_en_o = ctl_q[11];

    // Flatten the register arrays onto the export buses
    for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix_out
        assign fixed_ranges_o[64*j +: 64] = fix_q[j];
    end
    for (genvar k = 0; k < NUM_VAR; k++) begin : g_var_out
        assign var_base_o[64*k +: 64] = base_q[k];
        assign var_mask_o[64*k +: 64] = mask_q[k];
    end

    // R11
    fault_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(wr_en));
    // R11
    fault_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(ctl_q) && $stable(fixed_ranges_o) &&
                   $stable(var_base_o) && $stable(var_mask_o)));
    // R3
    cap_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(acc_addr) == CAP_IDX) |=> fault);
    // R5
    ctl_type_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(ctl_q[7:0], WC_OK));
    // R6
    ctl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[9:8] == 2'b00) && (ctl_q[63:12] == '0));
    // R12
    unmapped_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(acc_addr) >= NREG) |=> fault);
endmodule

// File: tb/sim_memtype_cfg_bank.sv
module sim_memtype_cfg_bank;
    localparam int NUM_VAR = 8;
    localparam int AW      = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic fault;
    logic [7:0] def_type_o;
    logic fixed_en_o, global_en_o;
    logic [11*64-1:0] fixed_ranges_o;
    logic [NUM_VAR*64-1:0] var_base_o, var_mask_o;

    logic [AW-1:0] w_addr = '0;
    logic w_wr = 1'b0;
    logic [63:0] w_data = '0;
    logic [63:0] w_rd;
    logic w_fault;
    logic [7:0] w_def;
    logic w_fe, w_ge;
    logic [11*64-1:0] w_fix;
    logic [NUM_VAR*64-1:0] w_base, w_mask;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    memtype_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .fault(fault),
        .def_type_o(def_type_o), .fixed_en_o(fixed_en_o), .global_en_o(global_en_o),
        .fixed_ranges_o(fixed_ranges_o), .var_base_o(var_base_o), .var_mask_o(var_mask_o)
    );

    memtype_cfg_bank #(.WC_OK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_addr(w_addr), .wr_en(w_wr),
        .wr_data(w_data), .rd_data(w_rd), .fault(w_fault),
        .def_type_o(w_def), .fixed_en_o(w_fe), .global_en_o(w_ge),
        .fixed_ranges_o(w_fix), .var_base_o(w_base), .var_mask_o(w_mask)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write through u0; returns at the next falling edge with the fault visible
    task automatic wr(input int a, input logic [63:0] d);
        acc_addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        acc_addr = AW'(a); #1; d = rd_data;
    endtask

    task automatic wr1(input int a, input logic [63:0] d);
        w_addr = AW'(a); w_data = d; w_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        w_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R1 fault", {63'd0, fault}, 64'd0);
        for (int a = 1; a < 29; a++) begin
            rd(a, v); check("R1 reg zero", v, 64'd0);
        end
        check("R1 enables", {54'd0, def_type_o, fixed_en_o, global_en_o}, 64'd0);
        rd(0, v); check("R2 capability", v, 64'h508);
    endtask

    task automatic t_cap_write();
        logic [63:0] v;
        wr(0, 64'h0);
        check("R3 fault", {63'd0, fault}, 64'd1);
        rd(0, v); check("R3 unchanged", v, 64'h508);
    endtask

    task automatic t_control();
        logic [63:0] v;
        wr(1, 64'hC06);
        check("R4 no fault", {63'd0, fault}, 64'd0);
        rd(1, v); check("R4 readback", v, 64'hC06);
        check("R4 exports", {54'd0, def_type_o, fixed_en_o, global_en_o},
              {54'd0, 8'd6, 1'b1, 1'b1});
    endtask

    task automatic t_bad_type();
        logic [63:0] v;
        logic [7:0] bad [5] = '{8'd2, 8'd3, 8'd7, 8'd8, 8'hFF};
        foreach (bad[i]) begin
            wr(1, {56'h0, bad[i]});
            check("R5 fault", {63'd0, fault}, 64'd1);
            rd(1, v); check("R5 unchanged", v, 64'hC06);
        end
    endtask

    task automatic t_rsvd_ctl();
        logic [63:0] v;
        int bits [4] = '{8, 9, 12, 63};
        foreach (bits[i]) begin
            wr(1, 64'h4 | (64'd1 << bits[i]));
            check("R6 fault", {63'd0, fault}, 64'd1);
            rd(1, v); check("R6 unchanged", v, 64'hC06);
        end
    endtask

    task automatic t_wc();
        logic [63:0] v;
        wr(1, 64'h801);
        check("R7 wc accepted", {63'd0, fault}, 64'd0);
        rd(1, v); check("R7 wc stored", v, 64'h801);
        wr1(1, 64'h801);
        check("R7 wc refused", {63'd0, w_fault}, 64'd1);
        w_addr = 5'd1; #1; check("R7 wc unchanged", w_rd, 64'd0);
        wr1(2, 64'h0000_0000_0001_0000);
        check("R7 wc fixed refused", {63'd0, w_fault}, 64'd1);
        w_addr = 5'd0; #1; check("R7 cap wc bit", w_rd, 64'h108);
    endtask

    task automatic t_fixed();
        logic [63:0] v;
        wr(5, 64'h0605_0401_0006_0504);
        check("R8 accepted", {63'd0, fault}, 64'd0);
        rd(5, v); check("R8 readback", v, 64'h0605_0401_0006_0504);
        check("R8 export", fixed_ranges_o[64*3 +: 64], 64'h0605_0401_0006_0504);
        wr(5, 64'h0605_0401_0206_0504);
        check("R8 bad byte fault", {63'd0, fault}, 64'd1);
        rd(5, v); check("R8 unchanged", v, 64'h0605_0401_0006_0504);
    endtask

    task automatic t_var();
        logic [63:0] v;
        wr(19, 64'h0000_0000_0020_0006);
        check("R9 base accepted", {63'd0, fault}, 64'd0);
        check("R9 base export", var_base_o[64*3 +: 64], 64'h0000_0000_0020_0006);
        wr(19, 64'h0000_0000_0040_0206);
        check("R9 bit9 fault", {63'd0, fault}, 64'd1);
        wr(19, 64'h0000_0010_0040_0006);
        check("R9 bit36 fault", {63'd0, fault}, 64'd1);
        wr(19, 64'h0000_0000_0040_0003);
        check("R9 type fault", {63'd0, fault}, 64'd1);
        rd(19, v); check("R9 unchanged", v, 64'h0000_0000_0020_0006);
        wr(20, 64'h0000_000F_FFE0_0800);
        check("R10 mask accepted", {63'd0, fault}, 64'd0);
        check("R10 mask export", var_mask_o[64*3 +: 64], 64'h0000_000F_FFE0_0800);
        wr(20, 64'h0000_001F_FFE0_0800);
        check("R10 bit36 fault", {63'd0, fault}, 64'd1);
        wr(20, 64'h0000_000F_FFE0_0801);
        check("R10 bit0 fault", {63'd0, fault}, 64'd1);
        rd(20, v); check("R10 unchanged", v, 64'h0000_000F_FFE0_0800);
    endtask

    task automatic t_pulse_b2b();
        logic [63:0] v;
        wr(3, 64'h7);
        check("R11 fault high", {63'd0, fault}, 64'd1);
        @(negedge clk);
        check("R11 fault one cycle", {63'd0, fault}, 64'd0);
        acc_addr = 5'd4; wr_data = 64'h0606_0606_0606_0606; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R11 first write no fault", {63'd0, fault}, 64'd0);
        wr_data = 64'h0606_0606_0606_0609;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check("R11 second write fault", {63'd0, fault}, 64'd1);
        rd(4, v); check("R11 first value kept", v, 64'h0606_0606_0606_0606);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        wr(30, 64'h0);
        check("R12 fault", {63'd0, fault}, 64'd1);
        rd(30, v); check("R12 read zero", v, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cap_write();
        t_control();
        t_bad_type();
        t_rsvd_ctl();
        t_wc();
        t_fixed();
        t_var();
        t_pulse_b2b();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule